// File: doc/BRIEF.md
# Configurable Logic Tile with Programmable Routing

This block is a small programmable fabric tile. It holds two configurable logic cells and a mux-based routing crossbar. Each cell contains a 3-input lookup table with two outputs. Each table output has its own flip-flop and its own select bit. The select bit decides whether the cell output is the registered value or the raw table value. The crossbar has two outputs, and each one picks one of four tile-internal signals. The crossbar feeds the inputs of the second cell. Because two of the crossbar inputs are the second cell's own flip-flops, that cell can implement small state machines.

The table contents, the output selects and the crossbar selects all come from one 40-bit configuration register. That register is loaded serially through a scan chain on the tile clock while the load enable is high. During a load, every tile flip-flop is held at zero, so the fabric stays inactive until the new configuration is in place.

Top module: `cfg_logic_tile`

## Requirements
- R1: A high `rst` at a rising edge clears the configuration register and all tile flip-flops; with that all-zero configuration, `dout` reads 0.
- R2: While `cfg_en` is high, each rising edge shifts `cfg_din` into bit 0 of the configuration register, moving every bit one place up. After 40 shifts, the first bit shifted in sits at bit 39. Field layout: bits 39:24 hold the table of cell 0, and bits 23:8 hold the table of cell 1. Within a table, bit 2*addr+k is output k at address addr = {a2,a1,a0}. Bits 7:4 are the output selects: bit 4+2*c+k belongs to cell c, output k, and 1 means registered. Bits 1:0 select crossbar output 0, and bits 3:2 select crossbar output 1.
- R3: A table output with its select at 0 equals, in the same cycle, the stored bit at the address formed by the cell inputs, so any 3-input function can be realised.
- R4: While `cfg_en` is low, each table output is captured into its flip-flop at every rising edge. An output whose select is 1 shows that flip-flop value, so it changes one edge after its inputs change.
- R5: Whenever `cfg_en` is high, every tile flip-flop is held at 0.
- R6: Crossbar output j equals input m[sel_j]. Inputs m0 and m1 are cell 0 outputs 0 and 1 (after their selects). Inputs m2 and m3 are the cell 1 flip-flops of outputs 0 and 1.
- R7: Cell 0 takes {a2,a1,a0} = `in_a[2:0]`. Cell 1 takes a2 = `in_b`, a1 = crossbar output 1, and a0 = crossbar output 0. `dout` = {cell1 out1, cell1 out0, cell0 out1, cell0 out0}.
- R8: With feedback through the crossbar, cell 1 can be configured as a 2-bit counter that advances when `in_b` is 1 and holds when it is 0.
- R9: While `cfg_en` is low, the configuration register does not change, whatever `cfg_din` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tile clock, also used for configuration shifting |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable; holds the fabric flip-flops at zero |
| cfg_din | input | 1 | Serial configuration data, first bit lands at the top of the register |
| in_a | input | 3 | Inputs a2..a0 of cell 0 |
| in_b | input | 1 | Input a2 of cell 1 |
| dout | output | 4 | Cell outputs {cell1 out1, cell1 out0, cell0 out1, cell0 out0} |

## Verification
The assertions check four things on every cycle. While loading, the configuration register shifts by one bit and takes `cfg_din`. Outside loading, the register holds still. Loading clears the flip-flops. Outside loading, each flip-flop takes the table value from the previous edge. The bench scenarios are needed for the rest, because a property cannot show them: that the table contents really form the intended functions, that the field order places bits where R2 says, that the crossbar picks the intended sources, and that the output selects separate same-cycle from next-edge behaviour. The counter run, and the reload from a nonzero count, show the feedback path and the hold during loading.

// File: rtl/cfg_tile_pkg.sv
package cfg_tile_pkg;
  localparam int LUT_IN   = 3;
  localparam int LUT_OUT  = 2;
  localparam int SW_OUT   = 2;
  localparam int N_CELL   = 2;
  localparam int LUT_BITS = (1 << LUT_IN) * LUT_OUT;
  localparam int SW_IN    = N_CELL * LUT_OUT;
  localparam int SW_SEL_W = $clog2(SW_IN);
  localparam int OSEL_W   = N_CELL * LUT_OUT;
  localparam int SW_W     = SW_OUT * SW_SEL_W;
  localparam int CFG_W    = N_CELL * LUT_BITS + OSEL_W + SW_W;
endpackage

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int W = cfg_tile_pkg::CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/logic_cell.sv
module logic_cell #(
  parameter int N_IN  = cfg_tile_pkg::LUT_IN,
  parameter int N_OUT = cfg_tile_pkg::LUT_OUT
) (
  input  logic                           clk,
  input  logic                           clr,
  input  logic [(1<<N_IN)*N_OUT-1:0]     table_bits,
  input  logic [N_OUT-1:0]               reg_sel,
  input  logic [N_IN-1:0]                addr,
  output logic [N_OUT-1:0]               lut_val,
  output logic [N_OUT-1:0]               ff_q,
  output logic [N_OUT-1:0]               y
);
  localparam int DEPTH = 1 << N_IN;

  logic [N_OUT-1:0] entry [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    assign entry[e] = table_bits[e*N_OUT +: N_OUT];
  end

  assign lut_val = entry[addr];

  always_ff @(posedge clk) begin
    if (clr) ff_q <= '0;
    else     ff_q <= lut_val;
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_osel
    assign y[k] = reg_sel[k] ? ff_q[k] : lut_val[k];
  end
endmodule

// File: rtl/route_xbar.sv
module route_xbar #(
  parameter int N_IN  = cfg_tile_pkg::SW_IN,
  parameter int N_OUT = cfg_tile_pkg::SW_OUT,
  parameter int SEL_W = cfg_tile_pkg::SW_SEL_W
) (
  input  logic [N_IN-1:0]        m,
  input  logic [N_OUT*SEL_W-1:0] sel,
  output logic [N_OUT-1:0]       o
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    assign o[j] = m[sel[j*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/cfg_logic_tile.sv
module cfg_logic_tile #(
  parameter int LUT_IN  = cfg_tile_pkg::LUT_IN,
  parameter int LUT_OUT = cfg_tile_pkg::LUT_OUT,
  parameter int SW_OUT  = cfg_tile_pkg::SW_OUT
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_en,
  input  logic                      cfg_din,
  input  logic [LUT_IN-1:0]         in_a,
  input  logic [LUT_IN-SW_OUT-1:0]  in_b,
  output logic [2*LUT_OUT-1:0]      dout
);
  localparam int LUT_BITS = (1 << LUT_IN) * LUT_OUT;
  localparam int SW_IN    = 2 * LUT_OUT;
  localparam int SEL_W    = $clog2(SW_IN);
  localparam int OSEL_W   = 2 * LUT_OUT;
  localparam int SW_W     = SW_OUT * SEL_W;
  localparam int CFG_W    = 2 * LUT_BITS + OSEL_W + SW_W;

  logic [CFG_W-1:0]   cfg_q;
  logic               ff_clr;
  logic [LUT_OUT-1:0] lut0, lut1, ff0, ff1, y0, y1;
  logic [SW_OUT-1:0]  sw_o;

  assign ff_clr = rst | cfg_en;

  cfg_shift_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .shift_en(cfg_en), .din(cfg_din), .q(cfg_q)
  );

  logic_cell #(.N_IN(LUT_IN), .N_OUT(LUT_OUT)) u_cell0 (
    .clk(clk), .clr(ff_clr),
    .table_bits(cfg_q[CFG_W-1 -: LUT_BITS]),
    .reg_sel(cfg_q[SW_W +: LUT_OUT]),
    .addr(in_a),
    .lut_val(lut0), .ff_q(ff0), .y(y0)
  );

  route_xbar #(.N_IN(SW_IN), .N_OUT(SW_OUT), .SEL_W(SEL_W)) u_xbar (
    .m({ff1, y0}),
    .sel(cfg_q[SW_W-1:0]),
    .o(sw_o)
  );

  logic_cell #(.N_IN(LUT_IN), .N_OUT(LUT_OUT)) u_cell1 (
    .clk(clk), .clr(ff_clr),
    .table_bits(cfg_q[CFG_W-1-LUT_BITS -: LUT_BITS]),
    .reg_sel(cfg_q[SW_W+LUT_OUT +: LUT_OUT]),
    .addr({in_b, sw_o}),
    .lut_val(lut1), .ff_q(ff1), .y(y1)
  );

  assign dout = {y1, y0};
endmodule

// File: rtl/cfg_logic_tile_chk.sv
module cfg_logic_tile_chk #(
  parameter int CFG_W   = cfg_tile_pkg::CFG_W,
  parameter int LUT_OUT = cfg_tile_pkg::LUT_OUT
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_en,
  input logic               cfg_din,
  input logic [CFG_W-1:0]   cfg_q,
  input logic [LUT_OUT-1:0] f0,
  input logic [LUT_OUT-1:0] f1,
  input logic [LUT_OUT-1:0] q0,
  input logic [LUT_OUT-1:0] q1
);
  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_q == {$past(cfg_q[CFG_W-2:0]), $past(cfg_din)});

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q));

  a_r5_ff_cleared: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (q0 == '0 && q1 == '0));

  a_r4_ff_tracks: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (q0 == $past(f0) && q1 == $past(f1)));
endmodule

bind cfg_logic_tile cfg_logic_tile_chk #(.CFG_W(CFG_W), .LUT_OUT(LUT_OUT)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_q(cfg_q),
  .f0(lut0), .f1(lut1), .q0(ff0), .q1(ff1)
);

// File: tb/test_cfg_logic_tile.sv
module test_cfg_logic_tile;
  localparam int CW = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic [2:0] in_a = '0;
  logic [0:0] in_b = '0;
  logic [3:0] dout;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_logic_tile i_cfg_logic_tile (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .in_a(in_a), .in_b(in_b), .dout(dout)
  );

  // {in_a, in_b, expected dout} for the combinational configuration
  localparam logic [7:0] VEC [8] = '{
    {3'b000, 1'b0, 4'b0000}, {3'b001, 1'b1, 4'b1001},
    {3'b011, 1'b1, 4'b1010}, {3'b111, 1'b1, 4'b1111},
    {3'b111, 1'b0, 4'b1011}, {3'b100, 1'b0, 4'b1001},
    {3'b110, 1'b0, 4'b1010}, {3'b000, 1'b1, 4'b1000}
  };

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%b expected %b", tag, got, exp);
    end
  endtask

  // kind 0: parity/majority, 1: and/or, 2: inverters, 3: counter, 4: identity
  function automatic logic [15:0] tbl(input int kind);
    logic [15:0] t = '0;
    for (int e = 0; e < 8; e++) begin
      logic [2:0] a;
      a = 3'(e);
      case (kind)
        0: begin t[2*e] = ^a; t[2*e+1] = ($countones(a) >= 2); end
        1: begin t[2*e] = &a; t[2*e+1] = |a; end
        2: begin t[2*e] = ~a[2]; t[2*e+1] = ~a[1]; end
        3: begin t[2*e] = a[2] ? ~a[0] : a[0];
                 t[2*e+1] = a[2] ? (a[1] ^ a[0]) : a[1]; end
        default: begin t[2*e] = a[0]; t[2*e+1] = a[1]; end
      endcase
    end
    return t;
  endfunction

  // R2 layout: {table0, table1, selects, xbar1 sel, xbar0 sel}
  function automatic logic [CW-1:0] make_cfg(input logic [15:0] t0, input logic [15:0] t1,
                                             input logic [3:0] osel, input logic [1:0] s0,
                                             input logic [1:0] s1);
    return {t0, t1, osel, s1, s0};
  endfunction

  task automatic load(input logic [CW-1:0] w);
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_din = w[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_din = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: dout=%b expected completion", dout);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] cfg_a, cfg_b, cfg_c;
    cfg_a = make_cfg(tbl(0), tbl(1), 4'b0000, 2'd0, 2'd1);
    cfg_b = make_cfg(tbl(2), tbl(3), 4'b1101, 2'd2, 2'd3);
    cfg_c = make_cfg(tbl(4), tbl(4), 4'b0000, 2'd1, 2'd0);

    repeat (3) @(negedge clk);
    check("R1 reset state", dout, 4'b0000);
    rst = 1'b0;

    // R3 / R7: combinational functions through both cells
    load(cfg_a);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      in_a = VEC[v][7:5];
      in_b = VEC[v][4];
      #1 check("R3 R7 lut vector", dout, VEC[v][3:0]);
    end

    // R6: crossbar swap, out0 <- m1, out1 <- m0
    load(cfg_c);
    @(negedge clk); in_a = 3'b001;
    #1 check("R6 route swap a", dout, 4'b1001);
    @(negedge clk); in_a = 3'b010;
    #1 check("R6 route swap b", dout, 4'b0110);

    // R5 / R8 / R9: counter in cell 1 via m2/m3 feedback
    in_a = 3'b100;
    in_b = 1'b1;
    load(cfg_b);
    check("R5 counter cleared after load", dout, 4'b0010);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      cfg_din = ~cfg_din;
      check("R8 R9 counter advance", dout, {2'(k % 4), 2'b10});
    end
    in_b = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R8 counter hold", dout, 4'b0110);
    end

    // R4: out0 registered, out1 combinational in cell 0
    in_a = 3'b000;
    #1 check("R4 comb now, reg old", dout, 4'b0110);
    @(negedge clk);
    check("R4 reg after edge", dout, 4'b0111);
    in_a = 3'b110;
    #1 check("R4 comb drops, reg holds", dout, 4'b0101);
    @(negedge clk);
    check("R4 reg follows", dout, 4'b0100);

    // R5: reload from nonzero count
    in_b = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 count before reload", dout, 4'b1100);
    load(cfg_b);
    check("R5 reload clears state", dout, 4'b0000);

    // R1: mid-run reset clears configuration
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_a = 3'b000;
    #1 check("R1 reset clears config", dout, 4'b0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule